// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Zero Bus Turnaround

This block is a synthesizable synchronous SRAM that stores 36-bit words split into four 9-bit byte lanes. Commands, addresses and write data are all taken on rising clock edges. The data phase of every accepted command, read or write, follows two enabled edges after the command. Because reads and writes have the same latency, a host can issue one command per cycle in any mix of directions and never leave the bus idle to turn it around.

A command either starts a new access or continues a burst. A new access needs all three chip selects to be true. A continuation steps through a four-word group, in either wrapping sequential order or XOR order. Per-lane write enables go with each command. A clock-enable input freezes the whole block. An asynchronous output enable can float the data outputs at any moment.

Top module: `p2s_sram`

## Requirements
- R1: A read command taken at enabled edge k puts the word on `dq_out` with `rd_valid` high after enabled edge k+2. A write command taken at edge k stores the `wdata` that is present at enabled edge k+2.
- R2: The block takes one command on every enabled edge, in any order of reads and writes. A read taken on the edge right after a write to the same address returns the newly written word.
- R3: On a load cycle (`burst_adv` = 0), `rd_nwr` = 1 selects a read and `rd_nwr` = 0 selects a write.
- R4: While `clk_en_n` = 1, the block ignores all synchronous inputs, and every pipeline register and `rd_valid`/`dq_out` hold their values.
- R5: A load starts an access only if `cs0_n` = 0, `cs1` = 1 and `cs2_n` = 0. Otherwise the cycle is a deselect: no write happens and `rd_valid` stays low for its data cycle. A continuation that follows a deselect is also a deselect.
- R6: With `burst_adv` = 1, the next address keeps the upper bits of the start address. Its two low bits are (start + n) mod 4 when `burst_ilv` was 0 at load, and start XOR n when it was 1, where n is the continuation count mod 4. The operation latched at load is reused.
- R7: On a write, `byte_we_n[i]` = 0 writes lane i, which is `wdata[9i+8:9i]`. The enables are taken with the command of that cycle, whether it is a load or a continuation.
- R8: When `oe_n` = 1, `dq_out` is high impedance and `dq_drive` is 0 at once. The pipeline is not affected.
- R9: `rd_valid` is 1 exactly in read data cycles, whatever the state of `oe_n`. `dq_drive` equals `rd_valid` AND NOT `oe_n`.
- R10: After reset the pipeline is empty: `rd_valid` and `dq_drive` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| burst_adv | input | 1 | 1 continues the burst, 0 loads a new command |
| rd_nwr | input | 1 | 1 read, 0 write (used on load) |
| burst_ilv | input | 1 | Burst order at load: 1 XOR order, 0 sequential |
| byte_we_n | input | 4 | Active-low lane write enables |
| addr | input | 8 | Word address |
| wdata | input | 36 | Write data, taken two enabled edges after its command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | 36 | Read data, high impedance unless driven |
| dq_drive | output | 1 | High while `dq_out` is driven |
| rd_valid | output | 1 | Marks read data cycles |

## Verification
A stage register that is off by one cycle shows up on `rd_valid` and `dq_out` two enabled cycles after the faulty command. A bad burst counter shows up as a wrong word on the next read of that burst. A write lost or misplaced by a wrong lane mask, a missed deselect or a stall that is not held stays hidden until that address is read again. For that reason, each address is written during the fill phase and read again many times in the random traffic. A stall that does not hold shows up at once as a shifted `rd_valid` pattern.

// File: rtl/p2s_pkg.sv
package p2s_pkg;
  localparam int unsigned BURST_LEN = 4;
  localparam int unsigned CNT_W     = $clog2(BURST_LEN);

  typedef logic [CNT_W-1:0] bcnt_t;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_XOR = 1'b1
  } burst_ord_e;

  // low address bits of burst beat idx for a given start and order
  function automatic bcnt_t burst_lo(bcnt_t start, bcnt_t idx, burst_ord_e ord);
    bcnt_t r;
    if (ord == ORD_XOR) r = start ^ idx;
    else                r = bcnt_t'(start + idx);
    return r;
  endfunction
endpackage

// File: rtl/p2s_issue.sv
// Command issue stage: loads new commands or steps the active burst.
module p2s_issue
  import p2s_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int S_W   = 2 + ADDR_W + LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              load,
  input  logic              sel_ok,
  input  logic              rd_in,
  input  logic              ord_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [LANES-1:0]  be_n_in,
  output logic [S_W-1:0]    s1_bus,
  output bcnt_t             s1_cnt
);
  logic              act_q, act_d;
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LANES-1:0]  be_q, be_d;
  bcnt_t             cnt_q, cnt_d;
  bcnt_t             start_q, start_d;
  burst_ord_e        ord_q, ord_d;

  always_comb begin
    act_d   = act_q;
    rd_d    = rd_q;
    addr_d  = addr_q;
    cnt_d   = cnt_q;
    start_d = start_q;
    ord_d   = ord_q;
    be_d    = ~be_n_in;
    if (load) begin
      act_d   = sel_ok;
      rd_d    = rd_in;
      addr_d  = addr_in;
      cnt_d   = '0;
      start_d = addr_in[CNT_W-1:0];
      ord_d   = burst_ord_e'(ord_in);
    end else begin
      cnt_d              = bcnt_t'(cnt_q + 1'b1);
      addr_d[CNT_W-1:0]  = burst_lo(start_q, cnt_d, ord_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      cnt_q   <= '0;
      start_q <= '0;
      ord_q   <= ORD_SEQ;
      be_q    <= '0;
    end else if (ce) begin
      act_q   <= act_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
      ord_q   <= ord_d;
      be_q    <= be_d;
    end
  end

  assign s1_bus = {act_q, rd_q, addr_q, be_q};
  assign s1_cnt = cnt_q;
endmodule

// File: rtl/p2s_stage.sv
// Enabled pipeline register with asynchronous reset.
module p2s_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (ce) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/p2s_lane_ram.sv
// One byte lane of storage: synchronous write, combinational read.
module p2s_lane_ram #(
  parameter int DEPTH  = 256,
  parameter int W      = 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/p2s_sram.sv
// Two-deep pipelined SRAM: address/control at edge k, data at edge k+2.
module p2s_sram #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              burst_adv,
  input  logic              rd_nwr,
  input  logic              burst_ilv,
  input  logic [LANES-1:0]  byte_we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive,
  output logic              rd_valid
);
  import p2s_pkg::*;

  localparam int S_W = 2 + ADDR_W + LANES;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic ce, load, sel_ok;
  assign ce     = ~clk_en_n;
  assign load   = ~burst_adv;
  assign sel_ok = ~cs0_n & cs1 & ~cs2_n;

  logic [S_W-1:0] s1_bus, s2_bus;
  bcnt_t          s1_cnt;

  p2s_issue #(.ADDR_W(ADDR_W), .LANES(LANES)) u_issue (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ce      (ce),
    .load    (load),
    .sel_ok  (sel_ok),
    .rd_in   (rd_nwr),
    .ord_in  (burst_ilv),
    .addr_in (addr),
    .be_n_in (byte_we_n),
    .s1_bus  (s1_bus),
    .s1_cnt  (s1_cnt)
  );

  p2s_stage #(.W(S_W)) u_stage2 (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ce    (ce),
    .d     (s1_bus),
    .q     (s2_bus)
  );

  logic              s2_act, s2_rd;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_be;
  assign {s2_act, s2_rd, s2_addr, s2_be} = s2_bus;

  logic wr_go, rd_go;
  assign wr_go = ce & s2_act & ~s2_rd;
  assign rd_go = ce & s2_act & s2_rd;

  logic [DATA_W-1:0] ram_rd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    p2s_lane_ram #(.DEPTH(DEPTH), .W(LANE_W)) u_ram (
      .clk   (clk),
      .we    (wr_go & s2_be[g]),
      .addr  (s2_addr),
      .wdata (wdata[g*LANE_W +: LANE_W]),
      .rdata (ram_rd[g*LANE_W +: LANE_W])
    );
  end

  // read output register
  logic              rv_q, rv_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;

  always_comb begin
    rv_d   = rv_q;
    rdat_d = rdat_q;
    if (ce) begin
      rv_d = rd_go;
      if (rd_go) rdat_d = ram_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rv_q   <= 1'b0;
      rdat_q <= '0;
    end else begin
      rv_q   <= rv_d;
      rdat_q <= rdat_d;
    end
  end

  assign rd_valid = rv_q;
  assign dq_drive = rv_q & ~oe_n;
  assign dq_out   = dq_drive ? rdat_q : {DATA_W{1'bz}};
endmodule

// File: rtl/p2s_sram_chk.sv
module p2s_sram_chk #(
  parameter int S_W   = 14,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             clk_en_n,
  input logic             burst_adv,
  input logic             cs0_n,
  input logic             cs1,
  input logic             cs2_n,
  input logic [S_W-1:0]   s1_bus,
  input logic [S_W-1:0]   s2_bus,
  input logic [CNT_W-1:0] s1_cnt,
  input logic             wr_go,
  input logic             rd_go,
  input logic             rd_valid
);
  assert_stage_advance_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !clk_en_n |=> (s2_bus == $past(s1_bus)));

  assert_fetch_to_valid_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_go |=> rd_valid);

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    clk_en_n |=> ($stable(s1_bus) && $stable(s2_bus) && $stable(rd_valid)));

  assert_deselect_load_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!clk_en_n && !burst_adv && (cs0_n || !cs1 || cs2_n)) |=> !s1_bus[S_W-1]);

  assert_deselect_cont_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!clk_en_n && burst_adv && !s1_bus[S_W-1]) |=> !s1_bus[S_W-1]);

  assert_beat_count_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!clk_en_n && burst_adv) |=> (s1_cnt == CNT_W'($past(s1_cnt) + 1'b1)));

  assert_write_no_valid_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_go |=> !rd_valid);
endmodule

bind p2s_sram p2s_sram_chk #(.S_W(S_W), .CNT_W(p2s_pkg::CNT_W)) u_chk (
  .clk       (clk),
  .rst_int_n (rst_int_n),
  .clk_en_n  (clk_en_n),
  .burst_adv (burst_adv),
  .cs0_n     (cs0_n),
  .cs1       (cs1),
  .cs2_n     (cs2_n),
  .s1_bus    (s1_bus),
  .s2_bus    (s2_bus),
  .s1_cnt    (s1_cnt),
  .wr_go     (wr_go),
  .rd_go     (rd_go),
  .rd_valid  (rd_valid)
);

// File: tb/sim_p2s_sram.sv
module sim_p2s_sram;
  localparam int DEPTH = 256;
  localparam int LN    = 4;
  localparam int LW    = 9;
  localparam int AW    = 8;
  localparam int DW    = 36;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, clk_en_n, cs0_n, cs1, cs2_n, burst_adv, rd_nwr, burst_ilv, oe_n;
  logic [LN-1:0] byte_we_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, dq_out;
  logic          dq_drive, rd_valid;

  p2s_sram u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs0_n(cs0_n), .cs1(cs1),
    .cs2_n(cs2_n), .burst_adv(burst_adv), .rd_nwr(rd_nwr), .burst_ilv(burst_ilv),
    .byte_we_n(byte_we_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .dq_out(dq_out), .dq_drive(dq_drive), .rd_valid(rd_valid)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R10";

  logic [DW-1:0] ref_mem [DEPTH];

  // bench-side command model
  bit            p1_act, p1_rd, p2_act, p2_rd;
  logic [AW-1:0] p1_addr, p2_addr;
  logic [LN-1:0] p1_be, p2_be;
  bit            b_act, b_rd, b_ilv;
  logic [AW-1:0] b_addr;
  logic [1:0]    b_start, b_cnt;
  bit            exp_valid;
  logic [DW-1:0] exp_data;

  function automatic logic [1:0] beat_lo(logic [1:0] st, logic [1:0] n, bit ilv);
    return ilv ? (st ^ n) : 2'(st + n);
  endfunction

  task automatic chk(bit ok, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  task automatic check_out(bit oen);
    chk(rd_valid == exp_valid, "rd_valid (R1 R9)", DW'(rd_valid), DW'(exp_valid));
    chk(dq_drive == (exp_valid && !oen), "dq_drive (R8)", DW'(dq_drive), DW'(exp_valid && !oen));
    if (exp_valid && !oen)
      chk(dq_out == exp_data, "read word (R1)", dq_out, exp_data);
  endtask

  // one clock: drive at negedge, update model, check at next negedge
  task automatic cyc(bit cen, bit c0n, bit c1, bit c2n, bit adv, bit rd,
                     logic [AW-1:0] a, logic [LN-1:0] ben, bit ilv, bit oen);
    logic [DW-1:0] wd;
    wd = {$urandom(), $urandom()} & {DW{1'b1}};
    clk_en_n = cen; cs0_n = c0n; cs1 = c1; cs2_n = c2n; burst_adv = adv;
    rd_nwr = rd; addr = a; byte_we_n = ben; burst_ilv = ilv; wdata = wd; oe_n = oen;
    if (!cen) begin
      if (p2_act && !p2_rd)
        for (int i = 0; i < LN; i++)
          if (p2_be[i]) ref_mem[p2_addr][i*LW +: LW] = wd[i*LW +: LW];
      exp_valid = p2_act && p2_rd;
      if (exp_valid) exp_data = ref_mem[p2_addr];
      p2_act = p1_act; p2_rd = p1_rd; p2_addr = p1_addr; p2_be = p1_be;
      if (!adv) begin
        b_act = !c0n && c1 && !c2n; b_rd = rd; b_addr = a;
        b_start = a[1:0]; b_cnt = 2'd0; b_ilv = ilv;
      end else begin
        b_cnt = 2'(b_cnt + 1);
        b_addr[1:0] = beat_lo(b_start, b_cnt, b_ilv);
      end
      p1_act = b_act; p1_rd = b_rd; p1_addr = b_addr; p1_be = ~ben;
    end
    @(negedge clk);
    check_out(oen);
  endtask

  task automatic ld(bit rd, logic [AW-1:0] a, logic [LN-1:0] ben, bit ilv);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, rd, a, ben, ilv, 1'b0);
  endtask

  task automatic cont(logic [LN-1:0] ben);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, ben, 1'b0, 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0, '1, 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1;
    burst_adv = 1'b0; rd_nwr = 1'b1; burst_ilv = 1'b0; byte_we_n = '1;
    addr = '0; wdata = '0; oe_n = 1'b0;
    {p1_act, p1_rd, p2_act, p2_rd, b_act, b_rd, b_ilv, exp_valid} = '0;
    p1_addr = '0; p2_addr = '0; p1_be = '0; p2_be = '0; b_addr = '0;
    b_start = '0; b_cnt = '0; exp_data = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: empty pipeline after reset
    cur_req = "R10";
    idle(4);

    // R3 R6: fill every address with sequential write bursts
    cur_req = "R3";
    for (int b = 0; b < DEPTH / 4; b++) begin
      ld(1'b0, AW'(b * 4), 4'b0000, 1'b0);
      repeat (3) cont(4'b0000);
    end
    idle(2);

    // R6: sequential from low bits 3, XOR from low bits 2, and wrap past four beats
    cur_req = "R6";
    ld(1'b1, 8'd7, '1, 1'b0); repeat (3) cont('1);
    ld(1'b1, 8'd10, '1, 1'b1); repeat (3) cont('1);
    ld(1'b1, 8'd41, '1, 1'b1); repeat (6) cont('1);
    ld(1'b0, 8'd62, 4'b0000, 1'b1); repeat (3) cont(4'b0000);
    ld(1'b1, 8'd60, '1, 1'b0); repeat (3) cont('1);
    idle(2);

    // R2: alternating write and read to one address, no gaps
    cur_req = "R2";
    for (int i = 0; i < 6; i++) begin
      ld(1'b0, 8'd20, 4'b0000, 1'b0);
      ld(1'b1, 8'd20, '1, 1'b0);
    end
    ld(1'b0, 8'd21, 4'b0000, 1'b0); ld(1'b1, 8'd21, '1, 1'b0);
    ld(1'b1, 8'd20, '1, 1'b0); ld(1'b0, 8'd22, 4'b0000, 1'b0);
    idle(2);

    // R7: partial lane writes on load and on continuation beats
    cur_req = "R7";
    ld(1'b0, 8'd30, 4'b1010, 1'b0); ld(1'b1, 8'd30, '1, 1'b0);
    ld(1'b0, 8'd32, 4'b0111, 1'b0); cont(4'b1111); cont(4'b1000); cont(4'b0001);
    ld(1'b1, 8'd32, '1, 1'b0); repeat (3) cont('1);
    idle(2);

    // R5: each select false blocks a write, continuation stays deselected
    cur_req = "R5";
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd50, 4'b0000, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd51, 4'b0000, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd52, 4'b0000, 1'b0, 1'b0);
    cont(4'b0000); cont(4'b0000);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'd50, '1, 1'b0, 1'b0);
    cont('1);
    ld(1'b1, 8'd50, '1, 1'b0); repeat (3) cont('1);
    idle(2);

    // R4: stalls with busy inputs in the middle of a read burst
    cur_req = "R4";
    ld(1'b1, 8'd100, '1, 1'b0);
    cont('1);
    repeat (3) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd100, 4'b0000, 1'b1, 1'b0);
    cont('1);
    repeat (2) cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd101, 4'b0000, 1'b0, 1'b0);
    cont('1);
    idle(3);

    // R8 R9: output enable off during read data cycles
    cur_req = "R8";
    ld(1'b1, 8'd120, '1, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, '1, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, '1, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, '0, '1, 1'b0, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, '0, '1, 1'b0, 1'b1);
    idle(2);

    // R2: random mixed traffic with stalls
    cur_req = "R2";
    for (int i = 0; i < 4000; i++) begin
      bit            cen, adv, bad, rd, ilv, oen;
      logic [LN-1:0] ben;
      logic [2:0]    which;
      cen   = ($urandom() % 8) == 0;
      adv   = ($urandom() % 3) != 0;
      bad   = ($urandom() % 10) == 0;
      rd    = $urandom() % 2;
      ilv   = $urandom() % 2;
      oen   = ($urandom() % 16) == 0;
      ben   = (($urandom() % 2) == 0) ? 4'b0000 : LN'($urandom());
      which = bad ? 3'(1 << ($urandom() % 3)) : 3'b000;
      cyc(cen, which[0], !which[1], which[2], adv, rd, AW'($urandom()), ben, ilv, oen);
    end
    idle(3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule